// File: doc/BRIEF.md
# Hub Address Map with Protected Top Slice

This block sits between the requesters of a shared 512 KB hub RAM and the RAM itself. It decodes a 20-bit byte address and turns it into a physical RAM address. The lower part of the RAM appears at the bottom of the map. The final 16 KB slice of the RAM is lifted to the very top of the 20-bit space. Everything between the two regions is an unmapped hole. Writes to the hole are discarded, and reads from it return zero. The RAM slice that is moved to the top cannot also be reached at its natural location.

A global control register holds three bits:
- A debug-interrupt enable.
- A write-protect flag for the top slice.
- A lock that freezes the other two bits until reset.

While protection is on, only a requester that is currently inside its debug service routine may write the top slice. Other writes there are dropped, and each dropped write raises a one-cycle violation strobe.

The block also supplies two fixed debug pointers:
- The address of the current requester's register save buffer.
- The address of the shared debug code area.

Both areas lie in the protected slice. Arbitration between requesters happens upstream of this block.

Top module: `hub_map_top`

## Requirements
- R1: An address below 0x7C000 is passed unchanged to the RAM (ram_en_o high, ram_addr_o equal to the address). The read data of such a read passes through to rdata_o one cycle after the request.
- R2: An address from 0x7C000 to 0xFBFFF, inclusive, is unmapped. ram_en_o and ram_we_o stay low for it, so writes there are discarded. In particular, the top slice cannot be reached at its natural location.
- R3: A read from the unmapped range returns zero on rdata_o one cycle after the request, whatever the RAM data input carries.
- R4: An address from 0xFC000 to 0xFFFFF maps to physical address (address − 0x80000), so 0xFC000 maps to 0x7C000 and 0xFFFFC maps to 0x7FFFC.
- R5: The control register updates only when ctl_wdata_i[31:3] equals 0x04000000, meaning the whole word is 0x2000_000x. Bit 0 is the debug enable, bit 1 is write-protect and bit 2 is lock. Any other prefix is ignored.
- R6: Once the lock bit is set, further control writes change nothing until reset.
- R7: While write-protect is set, a write to the top range goes to the RAM only if isr_active_i[req_id_i] is high. Otherwise ram_we_o stays low. Reads of the top range are never blocked.
- R8: Each dropped protected write makes viol_o high for exactly the following cycle.
- R9: After reset, lock, write-protect and debug enable are all 0, so dbg_en_o is 0, viol_o is 0 and writes to the top range pass.
- R10: save_ptr_o equals 0xFF000 + 256·(15 − req_id_i), which is 0xFFC00 for requester 3. code_ptr_o equals 0xFEF00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request present |
| req_id_i | input | 3 | Index of the requester |
| req_addr_i | input | 20 | Hub byte address |
| req_we_i | input | 1 | Request is a write |
| req_wdata_i | input | 32 | Write data |
| isr_active_i | input | 8 | Per-requester flag: inside its debug service routine |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 32 | Control command word |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable after gating |
| ram_addr_o | output | 19 | Physical RAM byte address |
| ram_wdata_o | output | 32 | Write data to RAM |
| ram_rdata_i | input | 32 | Read data from RAM, one cycle after the request |
| rdata_o | output | 32 | Read data to the requester, zero for unmapped reads |
| dbg_en_o | output | 1 | Global debug-interrupt enable |
| viol_o | output | 1 | Dropped protected write, one-cycle strobe |
| save_ptr_o | output | 20 | Save-buffer address of the current requester |
| code_ptr_o | output | 20 | Shared debug code area address |

## Verification
The bench builds the block with its default parameters:
- 20-bit map, 512 KB RAM, 16 KB top slice, 8 requesters.

This configuration puts the low, hole and top boundaries at the exact addresses named in the requirements, so each edge can be probed on both sides. With eight requesters, the bench can show that one requester's debug flag cannot unlock another requester's protected write. The save pointer is checked at the middle of its 16-slot range.

// File: rtl/hub_map_pkg.sv
package hub_map_pkg;

    typedef enum logic [1:0] {
        RGN_LOW  = 2'd0,
        RGN_HOLE = 2'd1,
        RGN_TOP  = 2'd2
    } region_e;

    typedef struct packed {
        logic lock;
        logic wprot;
        logic dben;
    } ctl_state_t;

    // command prefix expected in bits 31:3 of a control write
    localparam logic [28:0] CTL_PREFIX = 29'h0400_0000;

    localparam int DBG_SLOTS     = 16;
    localparam int DBG_SLOT_BYTES = 256;

endpackage

// File: rtl/hub_addr_decode.sv
module hub_addr_decode
    import hub_map_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int RAM_BYTES = 524288,
    parameter int TOP_BYTES = 16384
) (
    input  logic [ADDR_W-1:0]              addr_i,
    output region_e                        region_o,
    output logic [$clog2(RAM_BYTES)-1:0]   phys_o
);
    localparam int PHYS_W     = $clog2(RAM_BYTES);
    localparam int LOW_END_I  = RAM_BYTES - TOP_BYTES;
    localparam int TOP_BASE_I = (1 << ADDR_W) - TOP_BYTES;
    localparam logic [ADDR_W-1:0] LOW_END  = ADDR_W'(LOW_END_I);
    localparam logic [ADDR_W-1:0] TOP_BASE = ADDR_W'(TOP_BASE_I);
    localparam logic [ADDR_W-1:0] SHIFT    = ADDR_W'(TOP_BASE_I - LOW_END_I);

    always_comb begin
        if (addr_i < LOW_END) begin
            region_o = RGN_LOW;
            phys_o   = PHYS_W'(addr_i);
        end else if (addr_i >= TOP_BASE) begin
            region_o = RGN_TOP;
            phys_o   = PHYS_W'(addr_i - SHIFT);
        end else begin
            region_o = RGN_HOLE;
            phys_o   = '0;
        end
    end

endmodule

// File: rtl/hub_ctl_reg.sv
module hub_ctl_reg
    import hub_map_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        we_i,
    input  logic [31:0] wdata_i,
    output ctl_state_t  state_o
);
    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i && !st_q.lock && (wdata_i[31:3] == CTL_PREFIX)) begin
            st_d.lock  = wdata_i[2];
            st_d.wprot = wdata_i[1];
            st_d.dben  = wdata_i[0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign state_o = st_q;

    AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.lock |=> ($stable(st_q.wprot) && $stable(st_q.dben) && st_q.lock)); // R6

    AST_BAD_PREFIX_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && wdata_i[31:3] != CTL_PREFIX) |=> $stable(st_q)); // R5

endmodule

// File: rtl/hub_dbg_ptr.sv
module hub_dbg_ptr
    import hub_map_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int ID_W   = 3
) (
    input  logic [ID_W-1:0]   id_i,
    output logic [ADDR_W-1:0] save_ptr_o,
    output logic [ADDR_W-1:0] code_ptr_o
);
    localparam int SAVE_BASE_I = (1 << ADDR_W) - DBG_SLOTS * DBG_SLOT_BYTES;
    localparam int CODE_BASE_I = SAVE_BASE_I - DBG_SLOT_BYTES;
    localparam logic [ADDR_W-1:0] SAVE_BASE = ADDR_W'(SAVE_BASE_I);

    logic [3:0] slot;

    always_comb begin
        slot       = ~(4'(id_i));
        save_ptr_o = SAVE_BASE | ADDR_W'({slot, 8'h00});
        code_ptr_o = ADDR_W'(CODE_BASE_I);
    end

endmodule

// File: rtl/hub_map_top.sv
module hub_map_top
    import hub_map_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int RAM_BYTES = 524288,
    parameter int TOP_BYTES = 16384,
    parameter int DATA_W    = 32,
    parameter int NUM_REQ   = 8
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          req_valid_i,
    input  logic [$clog2(NUM_REQ)-1:0]    req_id_i,
    input  logic [ADDR_W-1:0]             req_addr_i,
    input  logic                          req_we_i,
    input  logic [DATA_W-1:0]             req_wdata_i,
    input  logic [NUM_REQ-1:0]            isr_active_i,
    input  logic                          ctl_we_i,
    input  logic [31:0]                   ctl_wdata_i,
    output logic                          ram_en_o,
    output logic                          ram_we_o,
    output logic [$clog2(RAM_BYTES)-1:0]  ram_addr_o,
    output logic [DATA_W-1:0]             ram_wdata_o,
    input  logic [DATA_W-1:0]             ram_rdata_i,
    output logic [DATA_W-1:0]             rdata_o,
    output logic                          dbg_en_o,
    output logic                          viol_o,
    output logic [ADDR_W-1:0]             save_ptr_o,
    output logic [ADDR_W-1:0]             code_ptr_o
);
    localparam int ID_W     = $clog2(NUM_REQ);
    localparam int PHYS_W   = $clog2(RAM_BYTES);
    localparam int LOW_END_I  = RAM_BYTES - TOP_BYTES;
    localparam int TOP_BASE_I = (1 << ADDR_W) - TOP_BYTES;
    localparam logic [PHYS_W-1:0] SLICE_PHYS = PHYS_W'(LOW_END_I);
    localparam logic [ADDR_W-1:0] HOLE_LO    = ADDR_W'(LOW_END_I);
    localparam logic [ADDR_W-1:0] HOLE_HI    = ADDR_W'(TOP_BASE_I);

    typedef struct packed {
        logic rd_hole;
        logic viol;
    } pipe_t;

    region_e    region;
    ctl_state_t ctl;
    pipe_t      pipe_d, pipe_q;
    logic       mapped;
    logic       wr_allowed;
    logic       drop;

    hub_addr_decode #(
        .ADDR_W    (ADDR_W),
        .RAM_BYTES (RAM_BYTES),
        .TOP_BYTES (TOP_BYTES)
    ) i_decode (
        .addr_i   (req_addr_i),
        .region_o (region),
        .phys_o   (ram_addr_o)
    );

    hub_ctl_reg i_ctl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (ctl_we_i),
        .wdata_i (ctl_wdata_i),
        .state_o (ctl)
    );

    hub_dbg_ptr #(
        .ADDR_W (ADDR_W),
        .ID_W   (ID_W)
    ) i_ptr (
        .id_i       (req_id_i),
        .save_ptr_o (save_ptr_o),
        .code_ptr_o (code_ptr_o)
    );

    always_comb begin
        mapped     = (region != RGN_HOLE);
        wr_allowed = (region == RGN_LOW) ||
                     (region == RGN_TOP && (!ctl.wprot || isr_active_i[req_id_i]));
        drop       = req_valid_i && req_we_i && (region == RGN_TOP) && !wr_allowed;

        ram_en_o    = req_valid_i && mapped;
        ram_we_o    = req_valid_i && req_we_i && wr_allowed;
        ram_wdata_o = req_wdata_i;

        pipe_d         = pipe_q;
        pipe_d.viol    = drop;
        if (req_valid_i && !req_we_i) begin
            pipe_d.rd_hole = !mapped;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= pipe_d;
    end

    assign rdata_o  = pipe_q.rd_hole ? '0 : ram_rdata_i;
    assign dbg_en_o = ctl.dben;
    assign viol_o   = pipe_q.viol;

    AST_HOLE_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_addr_i >= HOLE_LO && req_addr_i < HOLE_HI) |-> (!ram_en_o && !ram_we_o)); // R2

    AST_PROT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ram_we_o && ram_addr_o >= SLICE_PHYS && ctl.wprot) |-> isr_active_i[req_id_i]); // R7

    AST_VIOL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_we_i && req_addr_i >= HOLE_HI && ctl.wprot && !isr_active_i[req_id_i])
        |=> viol_o); // R8

    AST_WE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ram_we_o |-> ram_en_o); // R1

endmodule

// File: tb/test_hub_map_top.sv
module test_hub_map_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic [2:0]  req_id = 0;
    logic [19:0] req_addr = 0;
    logic        req_we = 0;
    logic [31:0] req_wdata = 0;
    logic [7:0]  isr = 0;
    logic        ctl_we = 0;
    logic [31:0] ctl_wdata = 0;
    logic        ram_en, ram_we;
    logic [18:0] ram_addr;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata = 0;
    logic [31:0] rdata;
    logic        dbg_en, viol;
    logic [19:0] save_ptr, code_ptr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    hub_map_top i_hub_map_top (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_id_i(req_id),
        .req_addr_i(req_addr), .req_we_i(req_we), .req_wdata_i(req_wdata),
        .isr_active_i(isr), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
        .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
        .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata), .rdata_o(rdata),
        .dbg_en_o(dbg_en), .viol_o(viol), .save_ptr_o(save_ptr), .code_ptr_o(code_ptr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [19:0] a, input bit we, input logic [2:0] id);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_we = we; req_id = id; req_wdata = 32'hA5A5_0000 | 32'(a);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 0; req_we = 0;
    endtask

    task automatic ctl_write(input logic [31:0] w);
        @(negedge clk);
        ctl_we = 1; ctl_wdata = w;
        @(negedge clk);
        ctl_we = 0;
    endtask

    task automatic t_reset();
        chk(dbg_en == 0, "R9 dbg_en", 32'(dbg_en), 0);
        chk(viol == 0, "R9 viol", 32'(viol), 0);
        access(20'hFC100, 1, 2);
        chk(ram_we == 1, "R9 top write open", 32'(ram_we), 1);
        idle();
    endtask

    task automatic t_low();
        access(20'h12344, 1, 0);
        chk(ram_en && ram_addr == 19'h12344, "R1 low addr", 32'(ram_addr), 32'h12344);
        chk(ram_wdata == 32'hA5A5_2344 && ram_we, "R1 low write", ram_wdata, 32'hA5A5_2344);
        access(20'h7BFFC, 0, 0);
        chk(ram_en && ram_addr == 19'h7BFFC, "R1 low edge", 32'(ram_addr), 32'h7BFFC);
        ram_rdata = 32'h1357_9BDF;
        @(negedge clk);
        chk(rdata == 32'h1357_9BDF, "R1 read pass", rdata, 32'h1357_9BDF);
        req_valid = 0;
    endtask

    task automatic t_top();
        access(20'hFC000, 0, 1);
        chk(ram_en && ram_addr == 19'h7C000, "R4 top base", 32'(ram_addr), 32'h7C000);
        access(20'hFFFFC, 1, 1);
        chk(ram_en && ram_we && ram_addr == 19'h7FFFC, "R4 top end", 32'(ram_addr), 32'h7FFFC);
        idle();
    endtask

    task automatic t_hole();
        access(20'h7C000, 1, 0);
        chk(!ram_en && !ram_we, "R2 hole low edge", {30'd0, ram_en, ram_we}, 0);
        access(20'hFBFFC, 1, 0);
        chk(!ram_en && !ram_we, "R2 hole high edge", {30'd0, ram_en, ram_we}, 0);
        access(20'h80000, 0, 0);
        chk(!ram_en, "R2 hole mid", 32'(ram_en), 0);
        ram_rdata = 32'hDEAD_BEEF;
        @(negedge clk);
        chk(rdata == 0, "R3 hole read zero", rdata, 0);
        req_valid = 0;
    endtask

    task automatic t_ctl();
        ctl_write(32'h2100_0001);
        chk(dbg_en == 0, "R5 bad prefix", 32'(dbg_en), 0);
        ctl_write(32'h2000_0003);
        chk(dbg_en == 1, "R5 dben set", 32'(dbg_en), 1);
    endtask

    task automatic t_prot();
        isr = 8'b0000_0010;
        access(20'hFD000, 1, 5);
        chk(ram_we == 0 && ram_en == 1, "R7 dropped write", 32'(ram_we), 0);
        @(negedge clk);
        req_valid = 0;
        chk(viol == 1, "R8 viol high", 32'(viol), 1);
        @(negedge clk);
        chk(viol == 0, "R8 viol one cycle", 32'(viol), 0);
        access(20'hFD000, 1, 1);
        chk(ram_we == 1, "R7 isr write", 32'(ram_we), 1);
        access(20'hFD000, 0, 5);
        chk(ram_en == 1, "R7 read not blocked", 32'(ram_en), 1);
        access(20'h01000, 1, 5);
        chk(ram_we == 1, "R7 low unaffected", 32'(ram_we), 1);
        idle();
        @(negedge clk);
        chk(viol == 0, "R8 no viol", 32'(viol), 0);
        isr = 0;
    endtask

    task automatic t_lock();
        ctl_write(32'h2000_0005);
        chk(dbg_en == 1, "R6 lock set", 32'(dbg_en), 1);
        ctl_write(32'h2000_0000);
        chk(dbg_en == 1, "R6 lock holds", 32'(dbg_en), 1);
        access(20'hFE000, 1, 0);
        chk(ram_we == 1, "R6 wprot frozen off", 32'(ram_we), 1);
        idle();
    endtask

    task automatic t_ptr();
        @(negedge clk);
        req_id = 3; #1;
        chk(save_ptr == 20'hFFC00, "R10 save ptr", 32'(save_ptr), 32'hFFC00);
        chk(code_ptr == 20'hFEF00, "R10 code ptr", 32'(code_ptr), 32'hFEF00);
        req_id = 0; #1;
        chk(save_ptr == 20'hFFF00, "R10 save ptr id0", 32'(save_ptr), 32'hFFF00);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_low();
        t_top();
        t_hole();
        t_ptr();
        t_ctl();
        t_prot();
        t_lock();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule